// File: doc/BRIEF.md
# Secondary Interrupt Controller with Line Passthrough

This block gathers 32 level-sensitive interrupt requests and presents them to a primary interrupt controller in two ways. All requests that are high and enabled in a mask register are ORed into one combined request on output line 31. A window of inputs, lines 21 to 30, can also be routed one-to-one to output lines of the same number. When one of these lines is routed, it follows its input. When it is not routed, it holds whatever value it last had.

Software reaches the block through a simple single-cycle register bus addressed by 32-bit word index. It can read the masked pending set, the raw levels and the enable mask. It can set and clear enable bits, with a shortcut pair for bit 0 that acts as a software-interrupt enable. It can also set and clear the routing bits. Read data comes back in the cycle after the read strobe. Word indices with no register read as zero, and writes to them have no effect.

Top module: `irq_sec_ctrl`

## Requirements
- R1: After reset the raw level, the enable mask and the routing register are zero, every bit of `irq_out` is low and `rdata` is zero.
- R2: The raw level register captures `irq_in` on every clock edge, and a read of word index 1 returns it.
- R3: A write to index 2 ORs `wdata` into the enable mask. A write to index 3 clears the mask bits that are 1 in `wdata`. A read of index 2 returns the mask.
- R4: A read of index 0 returns the raw level ANDed with the enable mask.
- R5: `irq_out[31]` is high exactly when some bit is set in both the raw level and the mask. It takes its new value at the clock edge that updates the level or the mask.
- R6: A read of index 4 returns raw level bit 0 in bit 0, with all other bits zero. A write of any nonzero value to index 4 sets mask bit 0, and a write of zero there changes nothing. A nonzero write to index 5 clears mask bit 0.
- R7: A write to index 8 ORs in `wdata` masked to bits 21..30 (0x7FE00000), so no other bit can ever be set. A write to index 9 clears the routing bits that are 1 in `wdata`. A read of index 8 returns the routing register.
- R8: For each line 21..30 whose routing bit is set, `irq_out[i]` equals the raw level bit `i`. It updates at the same edge as the raw level.
- R9: A line 21..30 whose routing bit is clear keeps its previous output value while its input changes. Setting the routing bit refreshes the line to the current level at that write's edge.
- R10: `irq_out[20:0]` is always low.
- R11: Reads of indices other than 0, 1, 2, 4 and 8 return zero. Writes to indices other than 2, 3, 4, 5, 8 and 9 leave every register and output unchanged.
- R12: `rdata` carries the selected value in the cycle after a cycle with `rd` high, and is zero after a cycle with `rd` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Level interrupt requests |
| wr | input | 1 | Write strobe, one cycle per write |
| rd | input | 1 | Read strobe |
| word_idx | input | 10 | Register word index (byte offset / 4) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_out | output | 32 | Bit 31 is the combined request; bits 21..30 are the routed lines |

## Verification
Every result in this block is due one clock edge after its stimulus:
- a new `irq_in` pattern shows up in the raw level, in `irq_out[31]` and in the routed lines at the next edge;
- a write changes the mask, the routing bits and the refreshed lines at its own edge;
- read data appears at the edge that follows the strobe.

The bench drives each stimulus on a falling edge and samples on the following falling edge, exactly one rising edge later. A result that comes a cycle early or late therefore shows up as a mismatch. Hold behaviour is checked by changing inputs while routing is off and then observing the lines before any later write.

// File: rtl/irq_sec_ctrl.sv
module irq_sec_ctrl #(
  parameter int IDX_W = 10,
  parameter int PT_LO = 21,
  parameter int PT_HI = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      irq_in,
  input  logic             wr,
  input  logic             rd,
  input  logic [IDX_W-1:0] word_idx,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output logic [31:0]      irq_out
);

  localparam logic [32:0] WIN33 = (33'd1 << (PT_HI + 1)) - (33'd1 << PT_LO);
  localparam logic [31:0] WIN   = WIN33[31:0];

  localparam logic [IDX_W-1:0] I_STAT  = IDX_W'(0);
  localparam logic [IDX_W-1:0] I_RAW   = IDX_W'(1);
  localparam logic [IDX_W-1:0] I_ENSET = IDX_W'(2);
  localparam logic [IDX_W-1:0] I_ENCLR = IDX_W'(3);
  localparam logic [IDX_W-1:0] I_SWSET = IDX_W'(4);
  localparam logic [IDX_W-1:0] I_SWCLR = IDX_W'(5);
  localparam logic [IDX_W-1:0] I_RTSET = IDX_W'(8);
  localparam logic [IDX_W-1:0] I_RTCLR = IDX_W'(9);

  logic [31:0] raw_q, mask_q, route_q, out_q, rdata_q;
  logic [31:0] mask_d, route_d, out_d, rmux;

  always_comb begin
    mask_d  = mask_q;
    route_d = route_q;
    if (wr) begin
      case (word_idx)
        I_ENSET: mask_d = mask_q | wdata;
        I_ENCLR: mask_d = mask_q & ~wdata;
        I_SWSET: if (|wdata) mask_d[0] = 1'b1;
        I_SWCLR: if (|wdata) mask_d[0] = 1'b0;
        I_RTSET: route_d = route_q | (wdata & WIN);
        I_RTCLR: route_d = route_q & ~wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    out_d     = ((route_d & irq_in) | (~route_d & out_q)) & WIN;
    out_d[31] = |(irq_in & mask_d);
  end

  always_comb begin
    case (word_idx)
      I_STAT:  rmux = raw_q & mask_q;
      I_RAW:   rmux = raw_q;
      I_ENSET: rmux = mask_q;
      I_SWSET: rmux = {31'd0, raw_q[0]};
      I_RTSET: rmux = route_q;
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q   <= '0;
      mask_q  <= '0;
      route_q <= '0;
      out_q   <= '0;
      rdata_q <= '0;
    end else begin
      raw_q   <= irq_in;
      mask_q  <= mask_d;
      route_q <= route_d;
      out_q   <= out_d;
      rdata_q <= rd ? rmux : '0;
    end
  end

  assign rdata   = rdata_q;
  assign irq_out = out_q;

  p_low_lines_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out[PT_LO-1:0] == '0);

  p_comb_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out[31] == |(raw_q & mask_q));

  p_route_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_out ^ raw_q) & route_q & WIN) == '0);

  p_route_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_out ^ $past(irq_out)) & ~route_q & ~$past(route_q) & WIN) == '0);

  p_route_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (route_q & ~WIN) == '0);

  p_rdata_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> rdata == '0);

endmodule

// File: tb/sim_irq_sec_ctrl.sv
module sim_irq_sec_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [9:0]  word_idx = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, irq_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_sec_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr(wr), .rd(rd),
    .word_idx(word_idx), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int idx, input logic [31:0] v);
    wr = 1'b1; word_idx = 10'(idx); wdata = v;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_reg(input int idx, output logic [31:0] v);
    rd = 1'b1; word_idx = 10'(idx);
    @(negedge clk);
    rd = 1'b0;
    v = rdata;
  endtask

  task automatic set_in(input logic [31:0] v);
    irq_in = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 irq_out", irq_out, 32'h0);
    chk("R1 rdata", rdata, 32'h0);
    rd_reg(0, v); chk("R1 status", v, 32'h0);
    rd_reg(1, v); chk("R1 raw", v, 32'h0);
    rd_reg(2, v); chk("R1 mask", v, 32'h0);
    rd_reg(8, v); chk("R1 route", v, 32'h0);
  endtask

  task automatic t_raw_mask;
    logic [31:0] v;
    set_in(32'hA5A5_0F0F);
    rd_reg(1, v); chk("R2 raw", v, 32'hA5A5_0F0F);
    chk("R5 no mask", {31'd0, irq_out[31]}, 32'h0);
    wr_reg(2, 32'h0000_00F0);
    wr_reg(2, 32'h0F00_0000);
    rd_reg(2, v); chk("R3 set or", v, 32'h0F00_00F0);
    wr_reg(3, 32'h0000_0030);
    rd_reg(2, v); chk("R3 clear", v, 32'h0F00_00C0);
    rd_reg(0, v); chk("R4 status", v, 32'h0500_0000);
    chk("R5 high", {31'd0, irq_out[31]}, 32'h1);
    set_in(32'h0000_0000);
    chk("R5 drop one cycle", {31'd0, irq_out[31]}, 32'h0);
    set_in(32'h0100_0000);
    chk("R5 rise one cycle", {31'd0, irq_out[31]}, 32'h1);
    wr_reg(3, 32'h0100_0000);
    chk("R5 mask clear edge", {31'd0, irq_out[31]}, 32'h0);
    wr_reg(3, 32'hFFFF_FFFF);
    set_in(32'h0);
  endtask

  task automatic t_soft;
    logic [31:0] v;
    set_in(32'h0000_0001);
    rd_reg(4, v); chk("R6 read bit0 high", v, 32'h1);
    wr_reg(4, 32'h0);
    rd_reg(2, v); chk("R6 zero write", v, 32'h0);
    wr_reg(4, 32'h0000_0005);
    rd_reg(2, v); chk("R6 set bit0", v, 32'h1);
    chk("R6 combined", {31'd0, irq_out[31]}, 32'h1);
    wr_reg(5, 32'h0000_0080);
    rd_reg(2, v); chk("R6 clear bit0", v, 32'h0);
    set_in(32'hFFFF_FFFE);
    rd_reg(4, v); chk("R6 read bit0 low", v, 32'h0);
    set_in(32'h0);
  endtask

  task automatic t_route_reg;
    logic [31:0] v;
    wr_reg(8, 32'hFFFF_FFFF);
    rd_reg(8, v); chk("R7 window", v, 32'h7FE0_0000);
    wr_reg(9, 32'h0020_0000);
    rd_reg(8, v); chk("R7 clear", v, 32'h7FC0_0000);
    wr_reg(9, 32'hFFFF_FFFF);
    rd_reg(8, v); chk("R7 clear all", v, 32'h0);
  endtask

  task automatic t_pass;
    wr_reg(8, 32'h0040_0000);
    set_in(32'h00C0_0000);
    chk("R8 routed follows", irq_out, 32'h0040_0000);
    set_in(32'h0080_0000);
    chk("R8 routed falls", irq_out, 32'h0);
    set_in(32'h0040_0000);
    wr_reg(9, 32'h0040_0000);
    set_in(32'h0);
    chk("R9 hold when off", irq_out, 32'h0040_0000);
    wr_reg(8, 32'h0040_0000);
    chk("R9 refresh on enable", irq_out, 32'h0);
    wr_reg(9, 32'hFFFF_FFFF);
    set_in(32'h7FFF_FFFF);
    chk("R10 low lines", irq_out, 32'h0);
    set_in(32'h0);
  endtask

  task automatic t_undef;
    logic [31:0] v;
    wr_reg(6, 32'hFFFF_FFFF);
    wr_reg(7, 32'hFFFF_FFFF);
    wr_reg(10, 32'hFFFF_FFFF);
    wr_reg(1023, 32'hFFFF_FFFF);
    set_in(32'hFFFF_FFFF);
    chk("R11 outputs", irq_out, 32'h0);
    rd_reg(2, v); chk("R11 mask kept", v, 32'h0);
    rd_reg(8, v); chk("R11 route kept", v, 32'h0);
    rd_reg(3, v); chk("R11 read idx3", v, 32'h0);
    rd_reg(6, v); chk("R11 read idx6", v, 32'h0);
    rd_reg(1023, v); chk("R11 read top", v, 32'h0);
    set_in(32'h0);
  endtask

  task automatic t_rdlat;
    logic [31:0] v;
    set_in(32'h1234_5678);
    rd_reg(1, v); chk("R12 data next cycle", v, 32'h1234_5678);
    @(negedge clk);
    chk("R12 idle zero", rdata, 32'h0);
    set_in(32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_raw_mask();
    t_soft();
    t_route_reg();
    t_pass();
    t_undef();
    t_rdlat();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule